// File: doc/BRIEF.md
# Double-Buffered Channel Status Transfer

This block holds channel status bytes for a two-channel digital audio transmitter in two copies. The host fills a user buffer through a synchronous register port. At a frame boundary the block copies that buffer into a transmit buffer, which the serializer reads through its own port. The host can therefore prepare the next status block without disturbing the one being sent. The host starts a copy by clearing a transfer-disable bit. The copy then begins at the next frame start.

The same register port reaches a small interrupt unit. It has a status register, a mask register and an active-low interrupt output. Source 0 is copy completion. Sources 1 and 2 are event inputs from neighbouring logic. Status bits are sticky. Reading the status register returns them and clears them. A copy takes one clock per byte. During a copy the user buffer refuses host writes. Setting the disable bit during a copy aborts it.

Top module: `cstat_xfer`

## Requirements
- R1: After reset, `irq_n` is 1, the status register (0x04) reads 0, the mask register (0x05) reads 0, the control register (0x06, bit 0 = transfer disable) reads 1, and every transmit buffer byte reads 0.
- R2: Register addresses 0x08 to 0x37 form the 48-byte user buffer, with read-back one cycle after `host_rd`. Address 0x08+2n holds channel A byte n and 0x08+2n+1 holds channel B byte n. The transmit buffer uses the same order, indexed by `ser_addr` = 2n+channel (A=0, B=1).
- R3: A copy begins only on the first `frame_start` that comes in a cycle after a write of 0 to the disable bit. A `frame_start` while disabled, or with no such write since the last copy, changes nothing.
- R4: A copy moves one byte per clock in rising index order. When the frame start is sampled at edge E0, byte i is copied at edge E(i+1), and the copy ends at E48. After completion the transmit buffer equals the user buffer.
- R5: Host writes to the user buffer while a copy is in progress are ignored.
- R6: Writing 1 to the disable bit during a copy stops it at once. That edge copies nothing, bytes already copied stay, later bytes keep their old values, and no completion event is raised.
- R7: When a copy completes and mask bit 0 is 1, status bit 0 is set at E48 and `irq_n` is 0 after that edge.
- R8: An event whose mask bit is 0 does not set its status bit and leaves `irq_n` at 1.
- R9: A status read returns the status bits and clears them all. `irq_n` stays 0 until that read and returns to 1 after it.
- R10: An unmasked event in the same cycle as a status read is not lost. The read returns the old bits, and the event's bit is set afterwards.
- R11: `aux_evt[0]` and `aux_evt[1]` drive status bits 1 and 2, enabled by mask bits 1 and 2. The mask register reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 8 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| aux_evt | input | 2 | Event pulses for interrupt sources 1 and 2 |
| ser_addr | input | 6 | Transmit buffer read index |
| ser_data | output | 8 | Transmit buffer byte at `ser_addr` |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench builds the block with its defaults: 48 bytes, 8-bit data and three interrupt sources. The full copy length is therefore exercised, so the bench can time completion to edge E48 and check the first and last buffer entries. With three sources, both auxiliary inputs are present. This lets the bench raise a masked event and an unmasked event against a status read in the same cycle. Random mask settings and random abort points then cover copies with and without a completion interrupt, and aborts anywhere in the buffer.

// File: rtl/cstat_xfer.sv
module cstat_xfer #(
  parameter int BYTES     = 48,
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int NSRC      = 3,
  parameter int UBASE     = 8,
  parameter int STAT_ADDR = 4,
  parameter int MASK_ADDR = 5,
  parameter int CTRL_ADDR = 6,
  localparam int IW       = $clog2(BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic            frame_start,
  input  logic [NSRC-2:0] aux_evt,
  input  logic [IW-1:0]   ser_addr,
  output logic [DW-1:0]   ser_data,
  output logic            irq_n
);
  localparam logic [IW-1:0] LAST = IW'(BYTES - 1);

  logic [DW-1:0]   ubuf [BYTES];
  logic [DW-1:0]   tbuf [BYTES];
  logic [NSRC-1:0] stat, mask;
  logic            dis, armed, busy;
  logic [IW-1:0]   idx;

  wire          ub_hit  = (host_addr >= AW'(UBASE)) && (host_addr < AW'(UBASE + BYTES));
  wire [IW-1:0] ub_idx  = IW'(host_addr - AW'(UBASE));
  wire          ctrl_wr = host_wr && host_addr == AW'(CTRL_ADDR);
  wire          mask_wr = host_wr && host_addr == AW'(MASK_ADDR);
  wire          stat_rd = host_rd && host_addr == AW'(STAT_ADDR);
  wire          abort   = ctrl_wr && host_wdata[0];
  wire          last    = idx == LAST;
  wire          done    = busy && !abort && last;
  wire [NSRC-1:0] evt   = {aux_evt, done};

  assign irq_n    = ~|(stat & mask);
  assign ser_data = tbuf[ser_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis   <= 1'b1;
      armed <= 1'b0;
      busy  <= 1'b0;
      idx   <= '0;
    end else begin
      if (ctrl_wr) begin
        dis   <= host_wdata[0];
        armed <= !host_wdata[0];
      end
      if (abort) begin
        busy <= 1'b0;
      end else if (busy) begin
        idx <= idx + 1'b1;
        if (last) busy <= 1'b0;
      end else if (frame_start && armed && !dis) begin
        busy  <= 1'b1;
        idx   <= '0;
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) begin
        ubuf[i] <= '0;
        tbuf[i] <= '0;
      end
    end else begin
      if (host_wr && ub_hit && !busy) ubuf[ub_idx] <= host_wdata;
      if (busy && !abort) tbuf[idx] <= ubuf[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= (stat_rd ? '0 : stat) | (evt & mask);
      if (mask_wr) mask <= host_wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      if (ub_hit)                            host_rdata <= ubuf[ub_idx];
      else if (host_addr == AW'(STAT_ADDR))  host_rdata <= DW'(stat);
      else if (host_addr == AW'(MASK_ADDR))  host_rdata <= DW'(mask);
      else if (host_addr == AW'(CTRL_ADDR))  host_rdata <= DW'(dis);
      else                                   host_rdata <= '0;
    end
  end
endmodule

// File: rtl/cstat_xfer_chk.sv
module cstat_xfer_chk #(
  parameter int NSRC = 3,
  parameter int IW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic [IW-1:0]   idx,
  input logic            last,
  input logic            abort,
  input logic            done,
  input logic            frame_start,
  input logic [NSRC-1:0] stat,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] evt,
  input logic            stat_rd,
  input logic            mask_wr,
  input logic            irq_n
);
  AST_START_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_start));                                  // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !abort && !last |=> busy && idx == $past(idx) + 1'b1);        // R4
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort |=> !busy);                                             // R6
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    done && mask[0] |=> stat[0] && !irq_n);                               // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[0] && !stat[0] |=> !stat[0]);                                   // R8
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n && !stat_rd && !mask_wr |=> !irq_n);                           // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !(|(evt & mask)) |=> stat == '0);                          // R9
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && evt[1] && mask[1] |=> stat[1]);                            // R10
endmodule

bind cstat_xfer cstat_xfer_chk #(.NSRC(NSRC), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .idx(idx), .last(last),
  .abort(abort), .done(done), .frame_start(frame_start), .stat(stat),
  .mask(mask), .evt(evt), .stat_rd(stat_rd), .mask_wr(mask_wr), .irq_n(irq_n)
);

// File: tb/cstat_xfer_tb.sv
module cstat_xfer_tb_top;
  localparam int CLK_PERIOD = 200;
  localparam int N = 48;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, frame_start = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic [7:0] host_rdata, ser_data;
  logic [1:0] aux_evt = '0;
  logic [5:0] ser_addr = '0;
  logic       irq_n;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] ub_m [N];
  logic [7:0] tx_m [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  cstat_xfer dut_i (.*);

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    finish_run();
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; tick(); host_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    host_rd = 1; host_addr = a; tick(); host_rd = 0; d = host_rdata;
  endtask

  function automatic logic [7:0] ub_addr(int n, int ch);
    return 8'(8 + 2 * n + ch);
  endfunction

  task automatic chk_tx(string tag);
    int bad = 0;
    for (int i = 0; i < N; i++) begin
      ser_addr = 6'(i); #1;
      if (ser_data !== tx_m[i]) begin
        if (bad == 0) $display("FAIL %s: tx[%0d] actual=%0h expected=%0h", tag, i, ser_data, tx_m[i]);
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic fill_random(int count);
    for (int k = 0; k < count; k++) begin
      int i = $urandom_range(0, N - 1);
      logic [7:0] v = 8'($urandom);
      wr(ub_addr(i / 2, i % 2), v);
      ub_m[i] = v;
    end
  endtask

  task automatic pulse_frame();
    frame_start = 1; tick(); frame_start = 0;
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20417));
    for (int i = 0; i < N; i++) begin ub_m[i] = 0; tx_m[i] = 0; end
    repeat (3) tick();
    rst_n = 1; tick();

    chk("R1 irq_n", irq_n, 1);
    rd(8'h04, d); chk("R1 status", d, 0);
    rd(8'h05, d); chk("R1 mask", d, 0);
    rd(8'h06, d); chk("R1 disable", d, 1);
    chk_tx("R1 tx zero");

    fill_random(N);
    wr(8'h08, 8'hA5); ub_m[0] = 8'hA5;
    wr(8'h37, 8'h5A); ub_m[47] = 8'h5A;
    rd(8'h08, d); chk("R2 first byte", d, 8'hA5);
    rd(8'h37, d); chk("R2 last byte", d, 8'h5A);
    for (int k = 0; k < 6; k++) begin
      int n = $urandom_range(0, 23), ch = $urandom_range(0, 1);
      rd(ub_addr(n, ch), d); chk("R2 readback", d, ub_m[2 * n + ch]);
    end

    pulse_frame(); repeat (N + 4) tick();
    chk_tx("R3 frame while disabled");
    wr(8'h05, 8'h01);
    rd(8'h05, d); chk("R11 mask readback", d, 1);
    wr(8'h06, 8'h00);
    repeat (5) tick();
    chk_tx("R3 no frame no copy");

    pulse_frame();
    begin
      int wi = $urandom_range(0, N - 1);
      logic [7:0] old = ub_m[wi];
      wr(ub_addr(wi / 2, wi % 2), ~old);
      repeat (46) tick();
      chk("R4 not yet done at E47", irq_n, 1);
      tick();
      chk("R7 irq at E48", irq_n, 0);
      for (int i = 0; i < N; i++) tx_m[i] = ub_m[i];
      chk_tx("R4 copy content");
      rd(ub_addr(wi / 2, wi % 2), d); chk("R5 write ignored while busy", d, old);
    end
    pulse_frame(); repeat (N + 2) tick();
    chk_tx("R3 no rearm no copy");
    chk("R9 irq held until read", irq_n, 0);
    rd(8'h04, d); chk("R9 status read", d, 1);
    chk("R9 irq released", irq_n, 1);
    rd(8'h04, d); chk("R9 status cleared", d, 0);

    for (int it = 0; it < 6; it++) begin
      int m0 = $urandom_range(0, 1);
      fill_random(8);
      wr(8'h05, 8'(m0));
      wr(8'h06, 8'h00);
      repeat ($urandom_range(0, 3)) tick();
      pulse_frame(); repeat (N) tick();
      for (int i = 0; i < N; i++) tx_m[i] = ub_m[i];
      chk_tx("R4 random copy");
      chk(m0 ? "R7 irq enabled" : "R8 irq masked", irq_n, m0 ? 0 : 1);
      rd(8'h04, d); chk(m0 ? "R7 status set" : "R8 status stays clear", d, m0);
    end

    for (int it = 0; it < 4; it++) begin
      int k = $urandom_range(2, 45);
      fill_random(N);
      wr(8'h05, 8'h01);
      wr(8'h06, 8'h00);
      pulse_frame();
      repeat (k - 1) tick();
      wr(8'h06, 8'h01);
      for (int i = 0; i <= k - 2; i++) tx_m[i] = ub_m[i];
      repeat (N + 4) tick();
      chk_tx("R6 partial copy after abort");
      chk("R6 no irq after abort", irq_n, 1);
      rd(8'h04, d); chk("R6 no completion status", d, 0);
    end

    wr(8'h05, 8'h03);
    aux_evt = 2'b10; tick(); aux_evt = 0;
    chk("R11 masked aux source", irq_n, 1);
    host_rd = 1; host_addr = 8'h04; aux_evt = 2'b01; tick();
    host_rd = 0; aux_evt = 0;
    chk("R10 read returns old bits", host_rdata, 0);
    chk("R10 event kept", irq_n, 0);
    rd(8'h04, d); chk("R11 aux source bit 1", d, 8'h02);
    chk("R9 released", irq_n, 1);

    finish_run();
  end
endmodule